// File: doc/BRIEF.md
# Prioritised Memory Protection Permission Checker

This block answers one question per request: may an access to a byte range proceed, and which of read, write and execute does the protection state allow there? The caller supplies the first byte address, the length in bytes, the requested permission mask and whether the requester runs at machine level. Alongside these come the already decoded inclusive bounds of every protection entry, whether each entry is enabled, and a four-bit lock/permission code per entry. Two global security bits, a lockdown mode and a machine whitelist mode, are also inputs. Programming of the entries and decoding of their address encodings happen elsewhere.

Entries are scanned from index 0 upward. The first enabled entry that the access touches decides the outcome. If the access lies only partly inside that entry, it is refused. If no enabled entry is touched, a default policy applies, and that policy depends on the security bits and the requester level. A second scan reports whether the 4 KiB page holding the first byte is covered uniformly by the entries, which tells a translation cache whether the result may be reused for the whole page. The decision logic is combinational. One register stage gives every result a fixed latency of one cycle.

Top module: `pmp_checker`

## Requirements
- R1: Entries are scanned in ascending index order. The first enabled entry that contains both the first and the last byte of the access decides the allowed mask. Entries with higher indices and the default policy are then not consulted.
- R2: If an enabled entry contains exactly one of the two end bytes, and no lower-indexed enabled entry has already decided the request, the access is refused: grant 0 and allowed mask 000.
- R3: The access covers addresses addr to addr+size-1. A size of 0 is treated as 4 bytes.
- R4: With lockdown mode off, a deciding entry gives machine level the mask RWX when its lock bit is clear. In every other case the mask is the entry's own R, W and X bits. The entry code is 4 bits, bit3=lock, bit2=R, bit1=W, bit0=X. Every mask is 3 bits, bit2=R, bit1=W, bit0=X.
- R5: With lockdown mode on and a machine-level requester, the code maps to a mask as follows. Codes 0, 1, 4-8 give none. Codes 2, 3, 14 give RW. Codes 9, 10 give X. Codes 11, 13 give RX. Codes 12, 15 give R.
- R6: With lockdown mode on and a lower-level requester, the code maps to a mask as follows. Codes 0, 8, 9, 12-14 give none. Codes 1, 10, 11 give X. Codes 2, 4, 15 give R. Codes 3, 6 give RW. Code 5 gives RX. Code 7 gives RWX.
- R7: When no enabled entry decides the request and whitelist mode is on, the access is refused with mask 000 at every level.
- R8: When no entry decides, whitelist mode is off and lockdown mode is on, machine level gets mask RW and a grant only when X is not requested. Every other such request is refused with mask 000.
- R9: When no entry decides and both security bits are off, machine level gets RWX and a grant. Lower levels are refused with mask 000.
- R10: When an entry decides, grant is 1 exactly when every requested bit is present in the allowed mask.
- R11: Page flag: the first enabled entry whose bounds span the whole page gives 1. The first whose start or end falls inside the page without spanning it gives 0. If no enabled entry touches the page, the flag is 1.
- R12: Results appear one clock after the request. The valid output copies the request valid with one cycle of delay. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_addr_i | input | AW | First byte address |
| req_size_i | input | SIZE_W | Access length in bytes, 0 means 4 |
| req_perm_i | input | 3 | Requested mask {R,W,X} |
| req_mach_i | input | 1 | 1 for machine-level requester |
| ent_on_i | input | N | Per-entry enable |
| ent_lo_i | input | N*AW | Per-entry inclusive low bound, entry i at [i*AW +: AW] |
| ent_hi_i | input | N*AW | Per-entry inclusive high bound |
| ent_code_i | input | N*4 | Per-entry {lock,R,W,X} |
| sec_mml_i | input | 1 | Lockdown mode |
| sec_mmwp_i | input | 1 | Machine whitelist mode |
| rsp_valid_o | output | 1 | Result valid |
| rsp_grant_o | output | 1 | Access permitted |
| rsp_allow_o | output | 3 | Allowed mask {R,W,X} |
| rsp_page_uniform_o | output | 1 | Page may be cached as a whole |

## Verification
The permission decision and the page-uniformity flag come out of the same register in the same cycle, yet they can be settled by different entries. The bench places a small entry that decides the access next to a lower-indexed or higher-indexed entry that touches only part of the page. It then checks both outputs of that single response against the bench's own model. The random phase packs entries into a few pages, so straddles, full matches and partial page coverage happen together often, and each response is compared field by field.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

    typedef struct packed {
        logic       valid;
        logic       grant;
        logic [2:0] allow;
        logic       uniform;
    } pmp_rsp_t;

    localparam logic [2:0] PM_NONE = 3'b000;
    localparam logic [2:0] PM_R    = 3'b100;
    localparam logic [2:0] PM_RW   = 3'b110;
    localparam logic [2:0] PM_X    = 3'b001;
    localparam logic [2:0] PM_RX   = 3'b101;
    localparam logic [2:0] PM_RWX  = 3'b111;

    // Lockdown-mode mapping for a machine-level requester (R5)
    function automatic logic [2:0] lockdown_mach(input logic [3:0] code);
        logic [2:0] m;
        case (code)
            4'd2, 4'd3, 4'd14:  m = PM_RW;
            4'd9, 4'd10:        m = PM_X;
            4'd11, 4'd13:       m = PM_RX;
            4'd12, 4'd15:       m = PM_R;
            default:            m = PM_NONE;
        endcase
        return m;
    endfunction

    // Lockdown-mode mapping for a lower-level requester (R6)
    function automatic logic [2:0] lockdown_user(input logic [3:0] code);
        logic [2:0] m;
        case (code)
            4'd1, 4'd10, 4'd11: m = PM_X;
            4'd2, 4'd4, 4'd15:  m = PM_R;
            4'd3, 4'd6:         m = PM_RW;
            4'd5:               m = PM_RX;
            4'd7:               m = PM_RWX;
            default:            m = PM_NONE;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pmp_entry_match.sv
module pmp_entry_match #(
    parameter int AW = 32
) (
    input  logic          on_i,
    input  logic [AW-1:0] lo_i,
    input  logic [AW-1:0] hi_i,
    input  logic [AW-1:0] first_i,
    input  logic [AW-1:0] last_i,
    input  logic [AW-1:0] pg_lo_i,
    input  logic [AW-1:0] pg_hi_i,
    output logic          full_o,
    output logic          partial_o,
    output logic          pg_cover_o,
    output logic          pg_touch_o
);
    logic in_first, in_last, lo_in_pg, hi_in_pg;

    always_comb begin
        in_first   = on_i && (first_i >= lo_i) && (first_i <= hi_i);
        in_last    = on_i && (last_i  >= lo_i) && (last_i  <= hi_i);
        full_o     = in_first && in_last;
        partial_o  = in_first ^ in_last;
        lo_in_pg   = (lo_i >= pg_lo_i) && (lo_i <= pg_hi_i);
        hi_in_pg   = (hi_i >= pg_lo_i) && (hi_i <= pg_hi_i);
        pg_cover_o = on_i && (lo_i <= pg_lo_i) && (hi_i >= pg_hi_i);
        pg_touch_o = pg_cover_o || (on_i && (lo_in_pg || hi_in_pg));
    end
endmodule

// File: rtl/pmp_rule_select.sv
module pmp_rule_select
    import pmp_chk_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0]   full_i,
    input  logic [N-1:0]   partial_i,
    input  logic [N-1:0]   pg_cover_i,
    input  logic [N-1:0]   pg_touch_i,
    input  logic [N*4-1:0] code_i,
    input  logic [2:0]     perm_i,
    input  logic           mach_i,
    input  logic           mml_i,
    input  logic           mmwp_i,
    output logic           grant_o,
    output logic [2:0]     allow_o,
    output logic           straddle_o,
    output logic           matched_o,
    output logic           uniform_o
);
    logic       decided, pg_seen;
    logic [3:0] sel_code;

    always_comb begin
        decided    = 1'b0;
        straddle_o = 1'b0;
        matched_o  = 1'b0;
        sel_code   = 4'd0;
        for (int i = 0; i < N; i++) begin
            if (!decided && partial_i[i]) begin
                straddle_o = 1'b1;
                decided    = 1'b1;
            end else if (!decided && full_i[i]) begin
                matched_o  = 1'b1;
                sel_code   = code_i[i*4 +: 4];
                decided    = 1'b1;
            end
        end

        pg_seen   = 1'b0;
        uniform_o = 1'b1;
        for (int i = 0; i < N; i++) begin
            if (!pg_seen && pg_touch_i[i]) begin
                uniform_o = pg_cover_i[i];
                pg_seen   = 1'b1;
            end
        end

        allow_o = PM_NONE;
        grant_o = 1'b0;
        if (straddle_o) begin
            allow_o = PM_NONE;
            grant_o = 1'b0;
        end else if (matched_o) begin
            if (!mml_i)
                allow_o = (mach_i && !sel_code[3]) ? PM_RWX : sel_code[2:0];
            else if (mach_i)
                allow_o = lockdown_mach(sel_code);
            else
                allow_o = lockdown_user(sel_code);
            grant_o = ((perm_i & allow_o) == perm_i);
        end else if (mmwp_i) begin
            allow_o = PM_NONE;
            grant_o = 1'b0;
        end else if (mml_i) begin
            grant_o = mach_i && !perm_i[0];
            allow_o = grant_o ? PM_RW : PM_NONE;
        end else begin
            grant_o = mach_i;
            allow_o = mach_i ? PM_RWX : PM_NONE;
        end
    end
endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
    import pmp_chk_pkg::*;
#(
    parameter int N         = 8,
    parameter int AW        = 32,
    parameter int SIZE_W    = 4,
    parameter int PAGE_BITS = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid_i,
    input  logic [AW-1:0]   req_addr_i,
    input  logic [SIZE_W-1:0] req_size_i,
    input  logic [2:0]      req_perm_i,
    input  logic            req_mach_i,
    input  logic [N-1:0]    ent_on_i,
    input  logic [N*AW-1:0] ent_lo_i,
    input  logic [N*AW-1:0] ent_hi_i,
    input  logic [N*4-1:0]  ent_code_i,
    input  logic            sec_mml_i,
    input  logic            sec_mmwp_i,
    output logic            rsp_valid_o,
    output logic            rsp_grant_o,
    output logic [2:0]      rsp_allow_o,
    output logic            rsp_page_uniform_o
);
    localparam logic [AW-1:0] DEF_SIZE = AW'(4);
    localparam logic [AW-1:0] PG_MASK  = AW'((64'd1 << PAGE_BITS) - 64'd1);

    logic [AW-1:0] eff_size, last_addr, pg_lo, pg_hi;
    logic [N-1:0]  full_w, partial_w, cover_w, touch_w;
    logic          grant_w, straddle_w, matched_w, uniform_w;
    logic [2:0]    allow_w;
    pmp_rsp_t      rsp_d, rsp_q;

    always_comb begin
        eff_size  = (req_size_i == '0) ? DEF_SIZE : AW'(req_size_i);
        last_addr = req_addr_i + eff_size - AW'(1);
        pg_lo     = req_addr_i & ~PG_MASK;
        pg_hi     = req_addr_i | PG_MASK;
    end

    for (genvar g = 0; g < N; g++) begin : g_ent
        pmp_entry_match #(.AW(AW)) u_match (
            .on_i       (ent_on_i[g]),
            .lo_i       (ent_lo_i[g*AW +: AW]),
            .hi_i       (ent_hi_i[g*AW +: AW]),
            .first_i    (req_addr_i),
            .last_i     (last_addr),
            .pg_lo_i    (pg_lo),
            .pg_hi_i    (pg_hi),
            .full_o     (full_w[g]),
            .partial_o  (partial_w[g]),
            .pg_cover_o (cover_w[g]),
            .pg_touch_o (touch_w[g])
        );
    end

    pmp_rule_select #(.N(N)) u_sel (
        .full_i     (full_w),
        .partial_i  (partial_w),
        .pg_cover_i (cover_w),
        .pg_touch_i (touch_w),
        .code_i     (ent_code_i),
        .perm_i     (req_perm_i),
        .mach_i     (req_mach_i),
        .mml_i      (sec_mml_i),
        .mmwp_i     (sec_mmwp_i),
        .grant_o    (grant_w),
        .allow_o    (allow_w),
        .straddle_o (straddle_w),
        .matched_o  (matched_w),
        .uniform_o  (uniform_w)
    );

    always_comb begin
        rsp_d         = rsp_q;
        rsp_d.valid   = req_valid_i;
        rsp_d.grant   = grant_w;
        rsp_d.allow   = allow_w;
        rsp_d.uniform = uniform_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid_o        = rsp_q.valid;
    assign rsp_grant_o        = rsp_q.grant;
    assign rsp_allow_o        = rsp_q.allow;
    assign rsp_page_uniform_o = rsp_q.uniform;

    a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid_o == $past(req_valid_i)));

    a_r10_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rsp_grant_o) |-> ((rsp_allow_o & $past(req_perm_i)) == $past(req_perm_i)));

    a_r2_straddle_denies: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && straddle_w) |-> (!rsp_grant_o && rsp_allow_o == 3'b000));

    a_r7_whitelist_default: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sec_mmwp_i && !matched_w) |-> (!rsp_grant_o && rsp_allow_o == 3'b000));

    a_r11_idle_page_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && ent_on_i == '0) |-> rsp_page_uniform_o);
endmodule

// File: tb/pmp_checker_test.sv
`timescale 1ns/1ps
module pmp_checker_test;
    localparam int N  = 8;
    localparam int AW = 32;
    localparam int SW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_size = '0;
    logic [2:0] req_perm = '0;
    logic req_mach = 1'b0;
    logic mml = 1'b0, mmwp = 1'b0;
    logic [AW-1:0] e_lo [N];
    logic [AW-1:0] e_hi [N];
    logic [3:0]    e_code [N];
    logic [N-1:0]  e_on = '0;
    logic [N*AW-1:0] lo_flat, hi_flat;
    logic [N*4-1:0]  code_flat;
    logic rsp_valid, rsp_grant, rsp_uni;
    logic [2:0] rsp_allow;
    int total = 0, bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            lo_flat[i*AW +: AW] = e_lo[i];
            hi_flat[i*AW +: AW] = e_hi[i];
            code_flat[i*4 +: 4] = e_code[i];
        end
    end

    pmp_checker #(.N(N), .AW(AW), .SIZE_W(SW), .PAGE_BITS(12)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
        .req_size_i(req_size), .req_perm_i(req_perm), .req_mach_i(req_mach),
        .ent_on_i(e_on), .ent_lo_i(lo_flat), .ent_hi_i(hi_flat), .ent_code_i(code_flat),
        .sec_mml_i(mml), .sec_mmwp_i(mmwp), .rsp_valid_o(rsp_valid),
        .rsp_grant_o(rsp_grant), .rsp_allow_o(rsp_allow), .rsp_page_uniform_o(rsp_uni)
    );

    function automatic logic [2:0] tbl_m(input logic [3:0] c);
        if (c inside {4'd2, 4'd3, 4'd14}) return 3'b110;
        if (c inside {4'd9, 4'd10})       return 3'b001;
        if (c inside {4'd11, 4'd13})      return 3'b101;
        if (c inside {4'd12, 4'd15})      return 3'b100;
        return 3'b000;
    endfunction

    function automatic logic [2:0] tbl_u(input logic [3:0] c);
        if (c inside {4'd1, 4'd10, 4'd11}) return 3'b001;
        if (c inside {4'd2, 4'd4, 4'd15})  return 3'b100;
        if (c inside {4'd3, 4'd6})         return 3'b110;
        if (c == 4'd5)                     return 3'b101;
        if (c == 4'd7)                     return 3'b111;
        return 3'b000;
    endfunction

    // expected {valid, grant, allow[2:0], uniform}
    function automatic logic [5:0] model();
        logic [31:0] last, plo, phi;
        logic uni, seen, fin, a, b, g;
        logic [2:0] al;
        last = req_addr + ((req_size == 0) ? 32'd4 : 32'(req_size)) - 32'd1;
        plo = req_addr & 32'hFFFF_F000;
        phi = plo | 32'h0000_0FFF;
        uni = 1'b1; seen = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (e_on[i] && !seen) begin
                if (e_lo[i] <= plo && e_hi[i] >= phi) begin uni = 1'b1; seen = 1'b1; end
                else if ((e_lo[i] >= plo && e_lo[i] <= phi) || (e_hi[i] >= plo && e_hi[i] <= phi)) begin
                    uni = 1'b0; seen = 1'b1;
                end
            end
        end
        fin = 1'b0; g = 1'b0; al = 3'b000;
        for (int i = 0; i < N; i++) begin
            if (e_on[i] && !fin) begin
                a = (req_addr >= e_lo[i]) && (req_addr <= e_hi[i]);
                b = (last >= e_lo[i]) && (last <= e_hi[i]);
                if (a != b) begin fin = 1'b1; g = 1'b0; al = 3'b000; end
                else if (a) begin
                    fin = 1'b1;
                    if (!mml) al = (req_mach && !e_code[i][3]) ? 3'b111 : e_code[i][2:0];
                    else al = req_mach ? tbl_m(e_code[i]) : tbl_u(e_code[i]);
                    g = ((req_perm & al) == req_perm);
                end
            end
        end
        if (!fin) begin
            if (mmwp) begin g = 1'b0; al = 3'b000; end
            else if (mml) begin g = req_mach && !req_perm[0]; al = g ? 3'b110 : 3'b000; end
            else begin g = req_mach; al = req_mach ? 3'b111 : 3'b000; end
        end
        return {1'b1, g, al, uni};
    endfunction

    task automatic chk(input string tag, input logic [5:0] exp);
        logic [5:0] got;
        got = {rsp_valid, rsp_grant, rsp_allow, rsp_uni};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b expected=%b (valid,grant,allow,uniform)", tag, got, exp);
        end
    endtask

    task automatic clear_entries();
        e_on = '0;
        for (int i = 0; i < N; i++) begin e_lo[i] = '0; e_hi[i] = '0; e_code[i] = '0; end
    endtask

    task automatic set_ent(input int i, input logic [31:0] lo, input logic [31:0] hi, input logic [3:0] c);
        e_lo[i] = lo; e_hi[i] = hi; e_code[i] = c; e_on[i] = 1'b1;
    endtask

    task automatic run(input logic [31:0] a, input logic [3:0] sz, input logic [2:0] p, input logic m);
        @(negedge clk);
        req_addr = a; req_size = sz; req_perm = p; req_mach = m; req_valid = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(8ns * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        logic [5:0] exp;
        seed = 32'd20240611;
        void'($urandom(seed));
        clear_entries();
        repeat (3) @(negedge clk);
        chk("R12 reset state", 6'b000000);
        total--; // reset check counted below with explicit valid=0
        total++;
        rst_n = 1'b1;

        // R12: valid low propagates
        @(negedge clk); req_valid = 1'b0; @(negedge clk);
        chk("R12 idle valid low", 6'b000001);

        // R1 priority, no fallback
        set_ent(0, 32'h100, 32'h1FF, 4'b0100);
        set_ent(1, 32'h000, 32'hFFF, 4'b0111);
        run(32'h150, 4'd4, 3'b100, 1'b0); chk("R1 first entry read", 6'b1_1_100_0);
        run(32'h150, 4'd4, 3'b010, 1'b0); chk("R1 R10 no fallback write", 6'b1_0_100_0);
        // R2 straddle
        run(32'h1FE, 4'd4, 3'b100, 1'b0); chk("R2 straddle", 6'b1_0_000_0);
        // R3 size zero
        run(32'h1FE, 4'd0, 3'b100, 1'b0); chk("R3 size0 straddle", 6'b1_0_000_0);
        run(32'h1FC, 4'd0, 3'b100, 1'b0); chk("R3 size0 fits", 6'b1_1_100_0);
        // R4 machine unlocked / locked
        run(32'h150, 4'd4, 3'b010, 1'b1); chk("R4 machine unlocked", 6'b1_1_111_0);
        e_code[0] = 4'b1100;
        run(32'h150, 4'd4, 3'b010, 1'b1); chk("R4 machine locked", 6'b1_0_100_0);

        // R11 page flag with a decision from a different entry
        clear_entries();
        set_ent(0, 32'h1000, 32'h1FFF, 4'b0111);
        set_ent(1, 32'h1100, 32'h11FF, 4'b0100);
        run(32'h1500, 4'd4, 3'b100, 1'b1); chk("R11 cover first", 6'b1_1_111_1);
        clear_entries();
        set_ent(0, 32'h1100, 32'h11FF, 4'b0100);
        set_ent(1, 32'h1000, 32'h1FFF, 4'b0111);
        run(32'h1500, 4'd4, 3'b100, 1'b1); chk("R11 partial first", 6'b1_1_111_0);
        clear_entries();
        set_ent(0, 32'h0, 32'h3FFF, 4'b0100);
        run(32'h1500, 4'd4, 3'b100, 1'b0); chk("R11 spans page", 6'b1_1_100_1);

        // defaults
        clear_entries();
        run(32'h40, 4'd4, 3'b111, 1'b1); chk("R9 machine default", 6'b1_1_111_1);
        run(32'h40, 4'd4, 3'b100, 1'b0); chk("R9 lower default", 6'b1_0_000_1);
        mmwp = 1'b1;
        run(32'h40, 4'd4, 3'b100, 1'b1); chk("R7 whitelist", 6'b1_0_000_1);
        mmwp = 1'b0; mml = 1'b1;
        run(32'h40, 4'd4, 3'b110, 1'b1); chk("R8 machine rw", 6'b1_1_110_1);
        run(32'h40, 4'd4, 3'b001, 1'b1); chk("R8 machine exec", 6'b1_0_000_1);
        run(32'h40, 4'd4, 3'b100, 1'b0); chk("R8 lower", 6'b1_0_000_1);

        // R5 / R6 full tables
        for (int c = 0; c < 16; c++) begin
            clear_entries();
            set_ent(0, 32'h0, 32'hFFF, 4'(c));
            run(32'h10, 4'd4, 3'b100, 1'b1);
            exp = {1'b1, tbl_m(4'(c))[2], tbl_m(4'(c)), 1'b1};
            chk($sformatf("R5 code %0d", c), exp);
            run(32'h10, 4'd4, 3'b100, 1'b0);
            exp = {1'b1, tbl_u(4'(c))[2], tbl_u(4'(c)), 1'b1};
            chk($sformatf("R6 code %0d", c), exp);
        end
        mml = 1'b0;

        // random mix
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                logic [31:0] b;
                b = ($urandom % 32'h4000) & 32'hFFFF_FFFC;
                e_lo[i] = b;
                e_hi[i] = b + (($urandom % 4 == 0) ? 32'h1FFF : ($urandom % 32'h400));
                e_code[i] = 4'($urandom);
                e_on[i] = ($urandom % 4) != 0;
            end
            mml  = ($urandom % 3) == 0;
            mmwp = ($urandom % 6) == 0;
            req_addr = $urandom % 32'h4000;
            req_size = 4'($urandom);
            req_perm = 3'($urandom % 7 + 1);
            req_mach = 1'($urandom);
            req_valid = 1'b1;
            exp = model();
            @(negedge clk);
            chk($sformatf("R1/R2/R10/R11 random %0d", k), exp);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule